// File: doc/BRIEF.md
# Dual-Read Register File with Falling-Edge Write

This block is the local register store of a processor data path. It holds a power-of-two number of words and lets the surrounding logic fetch two operands at once while a result is stored. There is a single write port: a write-address decoder turns the address into a one-hot set of word enables. There are two read ports, A and B, and each has its own address decoder and one-hot select network. Every stored bit is a flip-flop with an enable and an asynchronous clear.

Storage updates on the falling clock edge, and only when the write enable is high. Reads are purely combinational. Each read port follows its address and the addressed word's contents with no clock involved, so an operand fetched during the high phase of the clock sees the value committed at the previous falling edge. An active-low asynchronous clear empties every word at once, whatever the clock is doing.

Top module: `dp_regfile`

## Requirements
- R1: The file holds 2^ADDR_W words of DATA_W bits each, and every address retains its own value independently of writes to any other address.
- R2: Read ports A and B are independent: each presents the word at its own address, including when both addresses differ or are equal.
- R3: With `wr_en` high, the word on `wr_data` is stored into the word selected by `wr_addr` at the falling edge of `clk`; a rising edge stores nothing.
- R4: The write decoder drives exactly one word enable when `wr_en` is high and none when it is low, so a write changes only the addressed word.
- R5: Read outputs are combinational: a change of `rd_addr_a` or `rd_addr_b` shows the newly addressed word without any clock edge.
- R6: A read of the word being written shows its old contents until the falling edge, and the new contents after it.
- R7: With `wr_en` low, no word changes at any clock edge, whatever `wr_addr` and `wr_data` carry.
- R8: While `rst_n` is low, every word reads as 0 with no clock edge needed, and writes attempted during that time are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst_n | input | 1 | Asynchronous clear, active low, zeroes every word |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Address of the word to write |
| wr_data | input | DATA_W | Word to store |
| rd_addr_a | input | ADDR_W | Read port A address |
| rd_data_a | output | DATA_W | Read port A data, combinational |
| rd_addr_b | input | ADDR_W | Read port B address |
| rd_data_b | output | DATA_W | Read port B data, combinational |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 16. That gives eight words, so the whole address space, including the top index, is filled with distinct patterns and read back through both ports in opposite orders. The 16-bit width leaves room for patterns whose upper and lower bytes differ. A stray enable or a crossed select line therefore changes a value that can be seen. The small depth also means one write to one word can be checked against all seven others within a few cycles.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Default geometry of the register file
    localparam int unsigned RF_ADDR_W_DEF = 3;
    localparam int unsigned RF_DATA_W_DEF = 16;

    // Number of words for a given address width
    function automatic int unsigned rf_depth(input int unsigned addr_w);
        return 32'd1 << addr_w;
    endfunction

endpackage

// File: rtl/rf_addr_decoder.sv
module rf_addr_decoder #(
    parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF,
    localparam int unsigned NUM_W = regfile_pkg::rf_depth(ADDR_W)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_W-1:0]  sel
);

    // One comparator per output line
    for (genvar i = 0; i < NUM_W; i++) begin : g_line
        assign sel[i] = en && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/rf_word_reg.sv
module rf_word_reg #(
    parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } word_state_t;

    word_state_t st_d, st_q;

    // Next state: the enable stands in for a gated clock
    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.word = d;
        end
    end

    // Falling-edge capture with asynchronous clear
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.word;

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF,
    parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF,
    localparam int unsigned NUM_W = regfile_pkg::rf_depth(ADDR_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] words [NUM_W],
    output logic [DATA_W-1:0] data
);

    logic [NUM_W-1:0] rsel;

    rf_addr_decoder #(.ADDR_W(ADDR_W)) u_rdec (
        .en   (1'b1),
        .addr (addr),
        .sel  (rsel)
    );

    // AND-OR select network driven by the one-hot lines
    always_comb begin
        data = '0;
        for (int i = 0; i < NUM_W; i++) begin
            data = data | (words[i] & {DATA_W{rsel[i]}});
        end
    end

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int unsigned ADDR_W = regfile_pkg::RF_ADDR_W_DEF,
    parameter int unsigned DATA_W = regfile_pkg::RF_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b
);

    localparam int unsigned NUM_W = regfile_pkg::rf_depth(ADDR_W);

    logic [NUM_W-1:0]  wr_sel;
    logic [DATA_W-1:0] words [NUM_W];

    // Write decoder: one-hot enables, all low without wr_en
    rf_addr_decoder #(.ADDR_W(ADDR_W)) u_wdec (
        .en   (wr_en),
        .addr (wr_addr),
        .sel  (wr_sel)
    );

    for (genvar i = 0; i < NUM_W; i++) begin : g_word
        rf_word_reg #(.DATA_W(DATA_W)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (wr_sel[i]),
            .d     (wr_data),
            .q     (words[i])
        );
    end

    rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_a (
        .addr  (rd_addr_a),
        .words (words),
        .data  (rd_data_a)
    );

    rf_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_b (
        .addr  (rd_addr_b),
        .words (words),
        .data  (rd_data_b)
    );

endmodule

module dp_regfile_checker #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned NUM_W = 32'd1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic [NUM_W-1:0]  wr_sel
);

    AST_WR_SEL_ONEHOT: assert property (@(negedge clk) disable iff (!rst_n)
        wr_en |-> $onehot(wr_sel)) else $error("AST_WR_SEL_ONEHOT");   // R4

    AST_WR_SEL_IDLE: assert property (@(negedge clk) disable iff (!rst_n)
        !wr_en |-> (wr_sel == '0)) else $error("AST_WR_SEL_IDLE");   // R4

    AST_WRITE_LANDS_A: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && rd_addr_a == $past(wr_addr))
        |-> rd_data_a == $past(wr_data)) else $error("AST_WRITE_LANDS_A");   // R3

    AST_WRITE_LANDS_B: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && rd_addr_b == $past(wr_addr))
        |-> rd_data_b == $past(wr_data)) else $error("AST_WRITE_LANDS_B");   // R2

    AST_IDLE_HOLDS: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && rd_addr_a == $past(rd_addr_a))
        |-> $stable(rd_data_a)) else $error("AST_IDLE_HOLDS");   // R7

    AST_CLEAR_ZERO: assert property (@(negedge clk)
        (!rst_n && !$past(rst_n)) |-> (rd_data_a == '0 && rd_data_b == '0))
        else $error("AST_CLEAR_ZERO");   // R8

endmodule

bind dp_regfile dp_regfile_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_sel    (wr_sel)
);

// File: tb/dp_regfile_bench.sv
module dp_regfile_bench;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr_a = '0;
    logic [AW-1:0] rd_addr_b = '0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dp_regfile #(.ADDR_W(AW), .DATA_W(DW)) u_dp_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b)
    );

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        return DW'((i * 16'h1357) ^ (16'hA5C3 + salt));
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a write that commits on the next falling edge
    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic read_pair(input int a, input int b);
        rd_addr_a = AW'(a); rd_addr_b = AW'(b); #1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < NW; i++) begin
            read_pair(i, NW - 1 - i);
            chk("R8 reset A", rd_data_a, '0);
            chk("R8 reset B", rd_data_b, '0);
        end
    endtask

    task automatic t_fill();
        for (int i = 0; i < NW; i++) do_write(i, pat(i, 0));
        for (int i = 0; i < NW; i++) begin
            read_pair(i, NW - 1 - i);
            chk("R1 fill A", rd_data_a, pat(i, 0));
            chk("R2 fill B", rd_data_b, pat(NW - 1 - i, 0));
        end
        read_pair(5, 5);
        chk("R2 same addr A", rd_data_a, pat(5, 0));
        chk("R2 same addr B", rd_data_b, pat(5, 0));
    endtask

    task automatic t_edge();
        // inputs set just after a falling edge, so the next edge is rising
        @(negedge clk); #1;
        read_pair(2, 2);
        wr_en = 1'b1; wr_addr = AW'(2); wr_data = 16'hBEEF;
        @(posedge clk); #1;
        chk("R3 no write on rising edge", rd_data_a, pat(2, 0));
        chk("R6 old value before fall", rd_data_b, pat(2, 0));
        @(negedge clk); #1;
        wr_en = 1'b0;
        chk("R3 written at falling edge", rd_data_a, 16'hBEEF);
        chk("R6 new value after fall", rd_data_b, 16'hBEEF);
    endtask

    task automatic t_single();
        do_write(6, 16'h0F0F);
        for (int i = 0; i < NW; i++) begin
            read_pair(i, i);
            if (i == 6) chk("R4 target word", rd_data_a, 16'h0F0F);
            else if (i == 2) chk("R4 neighbour kept", rd_data_a, 16'hBEEF);
            else chk("R4 neighbour kept", rd_data_a, pat(i, 0));
        end
    endtask

    task automatic t_idle();
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            wr_en = 1'b0; wr_addr = AW'(k + 1); wr_data = 16'hFFFF - 16'(k);
            @(negedge clk); #1;
        end
        for (int i = 0; i < NW; i++) begin
            read_pair(i, i);
            if (i == 6) chk("R7 idle hold", rd_data_b, 16'h0F0F);
            else if (i == 2) chk("R7 idle hold", rd_data_b, 16'hBEEF);
            else chk("R7 idle hold", rd_data_b, pat(i, 0));
        end
    endtask

    task automatic t_comb();
        // clock low, no edge while addresses move
        @(negedge clk); #1;
        read_pair(0, 7);
        chk("R5 comb A", rd_data_a, pat(0, 0));
        chk("R5 comb B", rd_data_b, pat(7, 0));
        read_pair(3, 6);
        chk("R5 comb A moved", rd_data_a, pat(3, 0));
        chk("R5 comb B moved", rd_data_b, 16'h0F0F);
    endtask

    task automatic t_clear();
        @(negedge clk); #1;
        read_pair(1, 4);
        rst_n = 1'b0; #1;
        chk("R8 clear immediate A", rd_data_a, '0);
        chk("R8 clear immediate B", rd_data_b, '0);
        wr_en = 1'b1; wr_addr = AW'(1); wr_data = 16'h1234;
        @(negedge clk); #1;
        wr_en = 1'b0;
        chk("R8 write ignored in clear", rd_data_a, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int i = 0; i < NW; i++) begin
            read_pair(i, i);
            chk("R8 all words cleared", rd_data_a, '0);
        end
        do_write(1, pat(1, 9));
        read_pair(1, 0);
        chk("R3 write after clear", rd_data_a, pat(1, 9));
        chk("R1 other word still zero", rd_data_b, '0);
    endtask

    initial begin
        #3;
        t_reset();
        @(posedge clk); #1;
        rst_n = 1'b1;
        t_fill();
        t_edge();
        t_single();
        t_idle();
        t_comb();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule